// File: doc/BRIEF.md
# Thermal fan PWM controller

This block drives a cooling fan with a pulse-width modulated output. The duty cycle comes from one of two places: software writes a width value through a small register port, or the block raises the width by itself when a sampled temperature code crosses one of a set of rising thresholds. The temperature code is a 16-bit value from an external sensor, presented with a one-cycle valid strobe; it converts to degrees as code × 501.3743 / 65536 − 273.6777, and the thresholds are parameters given in that code space.

A duty increase made by the hardware is announced twice: a temperature-increase event at once, and a PWM-changed event after a settle delay that gives the fan time to reach its new speed. A software width write announces itself with a PWM-changed event only. Events are latched in a pending register that software clears by writing ones, and a mask register decides which pending events drive the active-high, level-sensitive interrupt output. The whole block stays in reset until software sets its enable bit.

Top module: `thermal_fan_pwm`

## Requirements
- R1: Until bit 0 of the enable register (offset 0x80) is 1, pwm_out and irq stay low, width writes are ignored and the width register reads PERIOD/NLEV; writing 0 there later returns the block to that state, clearing level, pending events and the settle delay.
- R2: The period register (offset 0xC0) reads PERIOD, which is nonzero, and ignores writes.
- R3: The width register (offset 0x84) takes the written value clamped to PERIOD; pwm_out is high for exactly width cycles in every window of PERIOD consecutive cycles.
- R4: A software width write while no settle delay runs sets pending bit 0 (PWM changed) one cycle later and does not set bit 2.
- R5: The temperature register (offset 0xC8) holds the last code presented with temp_valid.
- R6: Threshold k (1 ≤ k < NLEV) is T_BASE + (k−1)·T_STEP; the target level is the highest k whose threshold the code reaches. If it exceeds the current level, the level takes it, width becomes PERIOD·(level+1)/NLEV and pending bit 2 (temperature increase) is set one cycle later.
- R7: Pending bit 0 is set exactly SETTLE_CYC cycles after the edge that recorded a hardware rise, and not earlier.
- R8: The level drops by one only when a sample falls below its current threshold minus HYST; a drop changes neither the width nor any pending bit, and a later rise above that threshold fires bit 2 again.
- R9: A software width write during a settle delay changes the width at once, restarts the delay, and its bit 0 report comes only when the restarted delay ends.
- R10: The mask register (offset 0x40) resets to 0xF and a 1 masks its source; the pending register (0x44) clears the bits written with 1; the source register (0x48) reads pending AND NOT mask; irq is high exactly when that is nonzero; pending bits 1 and 3 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset for reads and writes |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data for addr (combinational) |
| temp_code | input | 16 | Temperature code from the sensor |
| temp_valid | input | 1 | One-cycle strobe qualifying temp_code |
| pwm_out | output | 1 | Fan PWM drive |
| irq | output | 1 | Active-high level interrupt |

## Verification
The bench builds the block with PERIOD=10, NLEV=4, SETTLE_CYC=40, thresholds at 0x9000, 0xA000 and 0xB000 and a hysteresis of 0x400. A ten-cycle frame lets every width value, including the clamp above the period, be counted cycle by cycle, and a forty-cycle settle delay puts the exact arrival of the delayed PWM-changed report, and its restart by a software write, within a short run. Widely spaced thresholds let random temperature codes walk the level up and down through the hysteresis band against a bench model.

// File: rtl/thermal_fan_pwm.sv
module thermal_fan_pwm #(
  parameter int unsigned PERIOD     = 4000,
  parameter int unsigned NLEV       = 4,
  parameter int unsigned SETTLE_CYC = 500_000_000,
  parameter int unsigned T_BASE     = 32'h9C00,
  parameter int unsigned T_STEP     = 32'h0800,
  parameter int unsigned HYST       = 32'h0200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic [15:0] temp_code,
  input  logic        temp_valid,
  output logic        pwm_out,
  output logic        irq
);
  localparam int PW = $clog2(PERIOD + 1);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam int LW = $clog2(NLEV + 1);

  localparam logic [7:0] A_MASK = 8'h40, A_PEND = 8'h44, A_SRC = 8'h48;
  localparam logic [7:0] A_EN = 8'h80, A_WID = 8'h84, A_PER = 8'hC0, A_TMP = 8'hC8;

  function automatic logic [31:0] thr(input int unsigned k);
    return T_BASE + (k - 1) * T_STEP;
  endfunction

  function automatic logic [PW-1:0] duty(input int unsigned k);
    return PW'(PERIOD * (k + 1) / NLEV);
  endfunction

  logic          en, settling;
  logic [3:0]    mask, pend, clr, set;
  logic [PW-1:0] width, pc;
  logic [15:0]   temp_q;
  logic [LW-1:0] lvl, up_lvl;
  logic [CW-1:0] cnt;

  always_comb begin
    up_lvl = '0;
    for (int unsigned k = 1; k < NLEV; k++)
      if (32'(temp_code) >= thr(k)) up_lvl = LW'(k);
  end

  wire wr_w = wr_en && addr == A_WID && en;
  wire rise = temp_valid && en && up_lvl > lvl;
  wire fall = temp_valid && en && !rise && lvl != '0 && (32'(temp_code) + HYST < thr(32'(lvl)));
  wire done = settling && cnt == CW'(SETTLE_CYC - 1);

  assign clr = (wr_en && addr == A_PEND) ? wr_data[3:0] : 4'b0;
  assign set = {1'b0, rise, 1'b0, done || (wr_w && !settling)};
  assign pwm_out = en && (pc < width);
  assign irq = |(pend & ~mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= 1'b0;
      mask <= 4'hF;
    end else if (wr_en) begin
      if (addr == A_EN)   en   <= wr_data[0];
      if (addr == A_MASK) mask <= wr_data[3:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      width    <= duty(0);
      pc       <= '0;
      temp_q   <= '0;
      lvl      <= '0;
      settling <= 1'b0;
      cnt      <= '0;
      pend     <= '0;
    end else begin
      pc <= (pc == PW'(PERIOD - 1)) ? '0 : pc + PW'(1);
      if (temp_valid) temp_q <= temp_code;
      if (rise) lvl <= up_lvl;
      else if (fall) lvl <= lvl - LW'(1);
      if (wr_w) width <= (wr_data > PERIOD) ? PW'(PERIOD) : wr_data[PW-1:0];
      else if (rise) width <= duty(32'(up_lvl));
      if (rise || (wr_w && settling)) begin
        settling <= 1'b1;
        cnt      <= '0;
      end else if (done) begin
        settling <= 1'b0;
      end else if (settling) begin
        cnt <= cnt + CW'(1);
      end
      pend <= (pend & ~clr) | set;
    end
  end

  always_comb begin
    case (addr)
      A_EN:    rd_data = {31'b0, en};
      A_MASK:  rd_data = {28'b0, mask};
      A_PEND:  rd_data = {28'b0, pend};
      A_SRC:   rd_data = {28'b0, pend & ~mask};
      A_WID:   rd_data = 32'(width);
      A_PER:   rd_data = PERIOD;
      A_TMP:   rd_data = {16'b0, temp_q};
      default: rd_data = '0;
    endcase
  end

  a_r3_width_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(width) <= PERIOD);
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!pwm_out && !irq));
  a_r7_settle_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    settling |-> 32'(cnt) < SETTLE_CYC);
  a_r7_settle_report: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_w && !rise && en) |=> (pend[0] && !settling));
  a_r6_rise_reports: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (pend[2] && settling));
  a_r8_fall_keeps_width: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !wr_w) |=> $stable(width));
endmodule

// File: tb/thermal_fan_pwm_tb.sv
module thermal_fan_pwm_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BP = 10, BN = 4, BS = 40;
  localparam int BB = 'h9000, BT = 'h1000, BH = 'h400;

  logic clk = 0, rst_n = 0, wr_en = 0, temp_valid = 0;
  logic [7:0] addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [15:0] temp_code = 0;
  logic pwm_out, irq;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_fan_pwm #(.PERIOD(BP), .NLEV(BN), .SETTLE_CYC(BS), .T_BASE(BB),
                    .T_STEP(BT), .HYST(BH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .temp_code(temp_code), .temp_valid(temp_valid),
    .pwm_out(pwm_out), .irq(irq));

  function automatic int duty_m(int k); return BP * (k + 1) / BN; endfunction
  function automatic int thr_m(int k); return BB + (k - 1) * BT; endfunction
  function automatic int level_m(int t);
    int l = 0;
    for (int k = 1; k < BN; k++) if (t >= thr_m(k)) l = k;
    return l;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output int d);
    addr = a; #1; d = int'(rd_data);
  endtask

  task automatic sample(input int t);
    @(negedge clk); temp_code = 16'(t); temp_valid = 1;
    @(negedge clk); temp_valid = 0;
  endtask

  task automatic count_high(output int n);
    n = 0;
    repeat (BP) begin @(negedge clk); n += int'(pwm_out); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int d, n, lvl, wm, w, t;
    void'($urandom(32'd7));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: held in reset before enable
    count_high(n); chk("R1 pwm low while off", n, 0);
    chk("R1 irq low while off", int'(irq), 0);
    wr(8'h84, 7); rd(8'h84, d); chk("R1 width write ignored", d, duty_m(0));
    // R2: period read-only
    rd(8'hC0, d); chk("R2 period", d, BP);
    wr(8'hC0, 3); rd(8'hC0, d); chk("R2 period write ignored", d, BP);
    wr(8'h80, 1);
    // R10: mask reset value
    rd(8'h40, d); chk("R10 mask reset", d, 15);
    rd(8'h44, d); chk("R10 pending reset", d, 0);
    // R3/R4: software width
    wr(8'h84, 5); rd(8'h84, d); chk("R3 width readback", d, 5);
    rd(8'h44, d); chk("R4 sw write pending", d, 1);
    chk("R10 irq masked", int'(irq), 0);
    count_high(n); chk("R3 high cycles", n, 5);
    wr(8'h40, 32'hE);
    chk("R10 irq unmasked", int'(irq), 1);
    rd(8'h48, d); chk("R10 source", d, 1);
    wr(8'h44, 1); rd(8'h44, d); chk("R10 w1c pending", d, 0);
    chk("R10 irq after clear", int'(irq), 0);
    wr(8'h40, 32'hF);
    for (int i = 0; i < 8; i++) begin
      w = $urandom_range(0, 15);
      wr(8'h84, w);
      rd(8'h84, d); chk("R3 clamped width", d, (w > BP) ? BP : w);
      count_high(n); chk("R3 random duty", n, (w > BP) ? BP : w);
      wr(8'h44, 15);
    end
    // R5: temperature register, no rise below first threshold
    sample('h1234); rd(8'hC8, d); chk("R5 temp register", d, 'h1234);
    rd(8'h44, d); chk("R6 no rise below threshold", d & 4, 0);
    // R6/R7: hardware rise and settle timing
    sample('hA100);
    rd(8'h84, d); chk("R6 hw width", d, duty_m(2));
    rd(8'h44, d); chk("R6 temp increase bit", d, 4);
    repeat (BS - 1) @(negedge clk);
    rd(8'h44, d); chk("R7 no early pwm-changed", d & 1, 0);
    @(negedge clk);
    rd(8'h44, d); chk("R7 pwm-changed after settle", d & 1, 1);
    wr(8'h44, 15);
    // R8: hysteresis
    sample('h9F00); sample('hA050);
    rd(8'h44, d); chk("R8 dip inside band keeps level", d, 0);
    wr(8'h84, 3); wr(8'h44, 15);
    sample('h9B00);
    rd(8'h84, d); chk("R8 fall keeps width", d, 3);
    rd(8'h44, d); chk("R8 fall no event", d, 0);
    sample('hA050);
    rd(8'h44, d); chk("R8 re-rise fires", d & 4, 4);
    rd(8'h84, d); chk("R8 re-rise width", d, duty_m(2));
    // R1: disable returns to reset state
    wr(8'h80, 0); wr(8'h80, 1);
    rd(8'h84, d); chk("R1 re-enable width", d, duty_m(0));
    rd(8'h44, d); chk("R1 re-enable pending", d, 0);
    // R9: sw write during settle restarts delay
    sample('hB100);
    rd(8'h84, d); chk("R9 hw width full", d, duty_m(3));
    repeat (9) @(negedge clk);
    wr(8'h84, 4);
    rd(8'h84, d); chk("R9 width immediate", d, 4);
    rd(8'h44, d); chk("R9 no immediate pwm-changed", d & 1, 0);
    repeat (BS - 1) @(negedge clk);
    rd(8'h44, d); chk("R9 restarted delay not over", d & 1, 0);
    @(negedge clk);
    rd(8'h44, d); chk("R9 pwm-changed after restart", d & 1, 1);
    // R6/R8: random temperature walk against model
    wr(8'h80, 0); wr(8'h80, 1);
    lvl = 0; wm = duty_m(0);
    for (int i = 0; i < 30; i++) begin
      t = 'h8800 + $urandom_range(0, 'h3800);
      wr(8'h44, 15);
      sample(t);
      n = level_m(t);
      rd(8'h44, d);
      if (n > lvl) begin
        lvl = n; wm = duty_m(n);
        chk("R6 random rise event", d & 4, 4);
      end else begin
        if (lvl > 0 && t + BH < thr_m(lvl)) lvl--;
        chk("R8 random no event", d & 4, 0);
      end
      rd(8'h84, d); chk("R6 random width", d, wm);
    end
    rd(8'h44, d); chk("R10 unused bits zero", d & 'hA, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule